// File: doc/BRIEF.md
# Double-Buffered Asynchronous Serial Transmitter

This block sends bytes as asynchronous serial frames on one output line. Software writes a byte into a holding register over a small register interface. The block then copies the byte into a separate shift register and sends the frame. While that frame is on the line, software can load the next byte. The frame format is chosen through a control register:

- an optional parity bit (even or odd), or a multiprocessor flag bit in its place;
- one or two stop bits.

Bit timing comes from an external baud tick pulse. Each bit lasts a fixed number of ticks.

The holding register is checked once per frame, at the moment the first stop bit starts. If a byte is waiting, it goes into the shifter, and its frame begins as soon as the last stop bit ends. If no byte is waiting, an end-of-transmission flag is set and the line stays at mark (1). There are two level interrupt outputs. One reports that the holding register can take a byte. The other reports that transmission has ended.

Top module: `dbuf_serial_tx`

## Requirements
- R1: After reset, `txd` is 1, status bit 0 (holding empty) and status bit 1 (transmission ended) both read 1, the control register reads 0, and both interrupt outputs are 0.
- R2: A write to address 0 (data) loads the holding register and clears both the holding-empty flag and the transmission-ended flag.
- R3: When the line is idle and the holding-empty flag is 0, the byte is copied into the shifter, the holding-empty flag returns to 1, and every written byte is sent exactly once.
- R4: A frame is a start bit (0), then DATA_W data bits least significant first, then an optional extra bit, then the stop bits (1). Every bit lasts TICKS baud ticks.
- R5: Control bit 2 adds a parity bit. Control bit 3 selects odd parity (1) or even parity (0), and parity is computed over the data bits only.
- R6: Control bit 5 selects multiprocessor mode. In this mode the extra bit is always present, carries control bit 6, and replaces parity whatever bit 2 holds.
- R7: Control bit 4 selects two stop bits instead of one.
- R8: A byte that is waiting when the first stop bit starts is sent with its start bit directly after the last stop bit, with no idle bit time between the frames.
- R9: If the holding register is empty when the first stop bit starts, the transmission-ended flag is set. After the stop bits the line stays at 1.
- R10: `irq_txe` is high exactly while holding-empty and control bit 0 are both 1. `irq_end` is high exactly while transmission-ended and control bit 1 are both 1.
- R11: Address 2 reads status with holding-empty in bit 0 and transmission-ended in bit 1. A write there with bit 1 at 0 clears the transmission-ended flag. A write to bit 0 has no effect. Address 1 is the control register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| baud_tick | input | 1 | One-cycle bit-rate enable pulse |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Register address (0 data, 1 control, 2 status) |
| bus_wdata | input | BUS_W | Register write data |
| bus_rdata | output | BUS_W | Register read data for `bus_addr` |
| txd | output | 1 | Serial output line, 1 at rest |
| irq_txe | output | 1 | Holding-register-empty interrupt level |
| irq_end | output | 1 | Transmission-ended interrupt level |

## Verification
The hardest case to reach from the ports is a byte that arrives after the previous frame has loaded but before that frame's first stop bit. Only this case gives back-to-back frames. The stimulus polls the status register until holding-empty returns to 1, and then writes at once, or after a random delay of up to a few hundred cycles. Some delays land before the stop bit and some after it, so both the chained path and the end-of-transmission path are exercised. The baud tick arrives irregularly, so bit boundaries fall at varying cycle offsets from the register writes.

// File: rtl/dbtx_pkg.sv
package dbtx_pkg;

  // Register addresses
  localparam int unsigned ADR_DATA = 0;
  localparam int unsigned ADR_CTRL = 1;
  localparam int unsigned ADR_STAT = 2;

  // Control register layout, bit 0 is txe_ie
  typedef struct packed {
    logic mp_bit;    // bit 6
    logic mp_mode;   // bit 5
    logic two_stop;  // bit 4
    logic par_odd;   // bit 3
    logic par_en;    // bit 2
    logic end_ie;    // bit 1
    logic txe_ie;    // bit 0
  } dbtx_cfg_t;

  localparam int unsigned CFG_W = $bits(dbtx_cfg_t);

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_EXTRA,
    ST_STOP1,
    ST_STOP2
  } dbtx_state_t;

endpackage

// File: rtl/dbtx_regs.sv
module dbtx_regs
  import dbtx_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned BUS_W  = 8,
  parameter int unsigned ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [BUS_W-1:0]  bus_wdata,
  input  logic              load_i,
  input  logic              end_set_i,
  output logic [DATA_W-1:0] hold_o,
  output logic              empty_o,
  output logic              tend_o,
  output dbtx_cfg_t         cfg_o
);

  logic              we_data, we_ctrl, we_stat;
  logic [DATA_W-1:0] hold_q, hold_d;
  logic              empty_q, empty_d;
  logic              tend_q, tend_d;
  dbtx_cfg_t         cfg_q, cfg_d;

  assign we_data = bus_we && (bus_addr == ADDR_W'(ADR_DATA));
  assign we_ctrl = bus_we && (bus_addr == ADDR_W'(ADR_CTRL));
  assign we_stat = bus_we && (bus_addr == ADDR_W'(ADR_STAT));

  always_comb begin
    hold_d  = hold_q;
    empty_d = empty_q;
    tend_d  = tend_q;
    cfg_d   = cfg_q;
    if (we_data) begin
      hold_d  = bus_wdata[DATA_W-1:0];
      empty_d = 1'b0;
      tend_d  = 1'b0;
    end else begin
      if (load_i)
        empty_d = 1'b1;
      if (we_stat && !bus_wdata[1])
        tend_d = 1'b0;
      else if (end_set_i)
        tend_d = 1'b1;
    end
    if (we_ctrl)
      cfg_d = dbtx_cfg_t'(bus_wdata[CFG_W-1:0]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q  <= '0;
      empty_q <= 1'b1;
      tend_q  <= 1'b1;
      cfg_q   <= '0;
    end else begin
      hold_q  <= hold_d;
      empty_q <= empty_d;
      tend_q  <= tend_d;
      cfg_q   <= cfg_d;
    end
  end

  assign hold_o  = hold_q;
  assign empty_o = empty_q;
  assign tend_o  = tend_q;
  assign cfg_o   = cfg_q;

endmodule

// File: rtl/dbtx_engine.sv
module dbtx_engine
  import dbtx_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned TICKS  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  logic              empty_i,
  input  logic [DATA_W-1:0] hold_i,
  input  logic              par_en_i,
  input  logic              par_odd_i,
  input  logic              mp_mode_i,
  input  logic              mp_bit_i,
  input  logic              two_stop_i,
  output logic              load_o,
  output logic              end_set_o,
  output logic              busy_o,
  output logic              txd_o
);

  localparam int unsigned CNT_W = (TICKS > 1) ? $clog2(TICKS) : 1;
  localparam int unsigned IDX_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(TICKS - 1);
  localparam logic [IDX_W-1:0] IDX_MAX = IDX_W'(DATA_W - 1);

  dbtx_state_t       state_q, state_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [IDX_W-1:0]  idx_q, idx_d;
  logic [DATA_W-1:0] sh_q, sh_d;
  logic              xbit_q, xbit_d;
  logic              xen_q, xen_d;
  logic              two_q, two_d;
  logic              more_q, more_d;
  logic              chain_q, chain_d;
  logic              bit_end, go_stop, capture;
  logic              cap_xbit;

  assign bit_end  = tick_i && (cnt_q == CNT_MAX);
  assign cap_xbit = mp_mode_i ? mp_bit_i : ((^hold_i) ^ par_odd_i);

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    idx_d   = idx_q;
    sh_d    = sh_q;
    xbit_d  = xbit_q;
    xen_d   = xen_q;
    two_d   = two_q;
    more_d  = more_q;
    chain_d = chain_q;
    go_stop = 1'b0;
    capture = 1'b0;
    load_o    = 1'b0;
    end_set_o = 1'b0;

    if (tick_i)
      cnt_d = bit_end ? '0 : cnt_q + 1'b1;

    case (state_q)
      ST_IDLE: begin
        cnt_d = '0;
        if (!empty_i) begin
          capture = 1'b1;
          state_d = ST_START;
        end
      end
      ST_START: begin
        if (bit_end) begin
          state_d = ST_DATA;
          idx_d   = '0;
        end
      end
      ST_DATA: begin
        if (bit_end) begin
          sh_d = sh_q >> 1;
          if (idx_q == IDX_MAX) begin
            if (xen_q) state_d = ST_EXTRA;
            else       go_stop = 1'b1;
          end else begin
            idx_d = idx_q + 1'b1;
          end
        end
      end
      ST_EXTRA: begin
        if (bit_end) go_stop = 1'b1;
      end
      ST_STOP1: begin
        if (bit_end) begin
          if (more_q)       state_d = ST_STOP2;
          else if (chain_q) state_d = ST_START;
          else              state_d = ST_IDLE;
        end
      end
      ST_STOP2: begin
        if (bit_end) state_d = chain_q ? ST_START : ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase

    // Holding register is examined only as the first stop bit begins
    if (go_stop) begin
      state_d = ST_STOP1;
      more_d  = two_q;
      chain_d = !empty_i;
      if (!empty_i) capture   = 1'b1;
      else          end_set_o = 1'b1;
    end

    if (capture) begin
      load_o = 1'b1;
      sh_d   = hold_i;
      xbit_d = cap_xbit;
      xen_d  = par_en_i || mp_mode_i;
      two_d  = two_stop_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      idx_q   <= '0;
      sh_q    <= '0;
      xbit_q  <= 1'b0;
      xen_q   <= 1'b0;
      two_q   <= 1'b0;
      more_q  <= 1'b0;
      chain_q <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      idx_q   <= idx_d;
      sh_q    <= sh_d;
      xbit_q  <= xbit_d;
      xen_q   <= xen_d;
      two_q   <= two_d;
      more_q  <= more_d;
      chain_q <= chain_d;
    end
  end

  always_comb begin
    case (state_q)
      ST_START: txd_o = 1'b0;
      ST_DATA:  txd_o = sh_q[0];
      ST_EXTRA: txd_o = xbit_q;
      default:  txd_o = 1'b1;
    endcase
  end

  assign busy_o = (state_q != ST_IDLE);

endmodule

// File: rtl/dbuf_serial_tx.sv
module dbuf_serial_tx
  import dbtx_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned BUS_W  = 8,
  parameter int unsigned ADDR_W = 2,
  parameter int unsigned TICKS  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              baud_tick,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [BUS_W-1:0]  bus_wdata,
  output logic [BUS_W-1:0]  bus_rdata,
  output logic              txd,
  output logic              irq_txe,
  output logic              irq_end
);

  logic [1:0]        rst_sync;
  logic              rst_sync_n;
  logic [DATA_W-1:0] hold;
  logic              tx_empty, tx_end;
  logic              eng_load, eng_end_set, eng_busy;
  logic              we_data;
  dbtx_cfg_t         cfg;

  // Asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_sync_n = rst_sync[1];

  assign we_data = bus_we && (bus_addr == ADDR_W'(ADR_DATA));

  dbtx_regs #(
    .DATA_W (DATA_W),
    .BUS_W  (BUS_W),
    .ADDR_W (ADDR_W)
  ) u_regs (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .load_i    (eng_load),
    .end_set_i (eng_end_set),
    .hold_o    (hold),
    .empty_o   (tx_empty),
    .tend_o    (tx_end),
    .cfg_o     (cfg)
  );

  dbtx_engine #(
    .DATA_W (DATA_W),
    .TICKS  (TICKS)
  ) u_engine (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .tick_i     (baud_tick),
    .empty_i    (tx_empty),
    .hold_i     (hold),
    .par_en_i   (cfg.par_en),
    .par_odd_i  (cfg.par_odd),
    .mp_mode_i  (cfg.mp_mode),
    .mp_bit_i   (cfg.mp_bit),
    .two_stop_i (cfg.two_stop),
    .load_o     (eng_load),
    .end_set_o  (eng_end_set),
    .busy_o     (eng_busy),
    .txd_o      (txd)
  );

  always_comb begin
    if (bus_addr == ADDR_W'(ADR_DATA))
      bus_rdata = BUS_W'(hold);
    else if (bus_addr == ADDR_W'(ADR_CTRL))
      bus_rdata = BUS_W'(cfg);
    else if (bus_addr == ADDR_W'(ADR_STAT))
      bus_rdata = BUS_W'({tx_end, tx_empty});
    else
      bus_rdata = '0;
  end

  assign irq_txe = tx_empty && cfg.txe_ie;
  assign irq_end = tx_end && cfg.end_ie;

endmodule

// File: rtl/dbuf_serial_tx_chk.sv
module dbuf_serial_tx_chk (
  input logic clk,
  input logic rst_n,
  input logic we_data,
  input logic load,
  input logic empty,
  input logic tend,
  input logic busy,
  input logic txd
);

  AST_LOAD_NEEDS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> !empty);                                                  // R3

  AST_LOAD_SETS_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    (load && !we_data) |=> empty);                                     // R3

  AST_WRITE_CLEARS_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    we_data |=> (!empty && !tend));                                    // R2

  AST_END_ONLY_WHEN_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    tend |-> empty);                                                   // R9

  AST_IDLE_IS_MARK: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> txd);                                                    // R9

  AST_FRAME_OPENS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> !txd);                                             // R4

endmodule

bind dbuf_serial_tx dbuf_serial_tx_chk u_chk (
  .clk     (clk),
  .rst_n   (rst_sync_n),
  .we_data (we_data),
  .load    (eng_load),
  .empty   (tx_empty),
  .tend    (tx_end),
  .busy    (eng_busy),
  .txd     (txd)
);

// File: tb/dbuf_serial_tx_bench.sv
`timescale 1ns/1ps
module dbuf_serial_tx_bench;

  localparam int DW = 8;
  localparam int BW = 8;
  localparam int AW = 2;
  localparam int T  = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          baud_tick = 1'b0;
  logic          bus_we = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [BW-1:0] bus_wdata = '0;
  logic [BW-1:0] bus_rdata;
  logic          txd, irq_txe, irq_end;

  always #4 clk = ~clk;

  dbuf_serial_tx #(.DATA_W(DW), .BUS_W(BW), .ADDR_W(AW), .TICKS(T)) u_dbuf_serial_tx (
    .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .txd(txd), .irq_txe(irq_txe), .irq_end(irq_end));

  int n_tests = 0;
  int n_fail  = 0;
  bit finished = 1'b0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Expected frame queue
  logic [DW-1:0] q_data [0:255];
  logic [6:0]    q_cfg  [0:255];
  int q_wr = 0, q_rd = 0;
  logic [6:0] cur_cfg = '0;

  function automatic logic exp_extra(input logic [DW-1:0] d, input logic [6:0] c);
    if (c[5]) return c[6];
    return (^d) ^ c[3];
  endfunction

  // Monitor and tick generator
  bit            mon_act = 1'b0;
  int            mcnt = 0, nb = 0, idle_ticks = 0;
  int            fr_start = 0, fr_done = 0, tick_total = 0;
  int            gaps [0:255];
  logic [DW-1:0] rx_d, cur_d;
  logic [6:0]    cur_c;

  task automatic mon_sample(input int k);
    logic hx;
    hx = cur_c[2] | cur_c[5];
    if (k == 0)
      chk(txd == 1'b0, "R4 start bit", txd, 0);
    else if (k <= DW) begin
      rx_d[k-1] = txd;
      if (k == DW) chk(rx_d == cur_d, "R4 data lsb first", rx_d, cur_d);
    end else if (hx && k == DW + 1)
      chk(txd == exp_extra(cur_d, cur_c), cur_c[5] ? "R6 multiprocessor bit" : "R5 parity bit",
          txd, exp_extra(cur_d, cur_c));
    else
      chk(txd == 1'b1, "R7 stop bit", txd, 1);
    if (k == nb - 1) begin
      mon_act = 1'b0;
      idle_ticks = 0;
      fr_done++;
    end
  endtask

  always @(negedge clk) begin
    if (!rst_n) begin
      mon_act = 1'b0;
      baud_tick = 1'b0;
    end else begin
      if (baud_tick) tick_total++;
      if (mon_act) begin
        if (baud_tick) begin
          mcnt++;
          if (mcnt % T == T / 2) mon_sample(mcnt / T);
        end
      end else if (txd == 1'b0) begin
        mon_act = 1'b1;
        mcnt = 0;
        gaps[fr_start % 256] = idle_ticks;
        fr_start++;
        if (q_rd == q_wr) begin
          chk(1'b0, "R3 frame without written byte", 1, 0);
          cur_d = '0; cur_c = '0;
        end else begin
          cur_d = q_data[q_rd % 256];
          cur_c = q_cfg[q_rd % 256];
          q_rd++;
        end
        nb = 2 + DW + ((cur_c[2] | cur_c[5]) ? 1 : 0) + (cur_c[4] ? 1 : 0);
      end else if (baud_tick)
        idle_ticks++;
      baud_tick = (($urandom % 4) != 0);
    end
  end

  // Bus tasks
  task automatic bus_wr(input logic [AW-1:0] a, input logic [BW-1:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
    if (a == 0) begin
      q_data[q_wr % 256] = d[DW-1:0];
      q_cfg[q_wr % 256]  = cur_cfg;
      q_wr++;
    end
    if (a == 1) cur_cfg = d[6:0];
  endtask

  task automatic bus_rd(input logic [AW-1:0] a, output logic [BW-1:0] d);
    @(negedge clk);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic wait_empty();
    logic [BW-1:0] st;
    do bus_rd(2, st); while (!st[0]);
  endtask

  task automatic wait_ticks(input int n);
    int mark;
    mark = tick_total;
    while (tick_total < mark + n) @(negedge clk);
  endtask

  task automatic wait_done();
    logic [BW-1:0] st;
    do bus_rd(2, st); while (!(st[1] && !mon_act && q_rd == q_wr));
    wait_ticks(T);
  endtask

  task automatic send_one(input logic [6:0] c, input logic [7:0] d);
    wait_done();
    bus_wr(1, {1'b0, c});
    bus_wr(0, d);
    wait_done();
  endtask

  // Watchdog
  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      n_tests++;
      $display("FAIL watchdog: actual=%0h expected=%0h", 0, 1);
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [BW-1:0] st;
    int low_seen;
    void'($urandom(32'd2024));

    // R1: reset state
    repeat (3) @(negedge clk);
    bus_addr = 2; #1;
    chk(bus_rdata == 8'h03, "R1 status during reset", bus_rdata, 8'h03);
    chk(txd == 1'b1, "R1 txd during reset", txd, 1);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    bus_rd(2, st);
    chk(st == 8'h03, "R1 status after reset", st, 8'h03);
    bus_rd(1, st);
    chk(st == 8'h00, "R1 control after reset", st, 0);
    chk({irq_txe, irq_end} == 2'b00, "R1 interrupts after reset", {irq_txe, irq_end}, 0);

    // R11: bit 0 write ignored, bit 1 write-zero clears end
    bus_wr(2, 8'h02);
    bus_rd(2, st);
    chk(st == 8'h03, "R11 status bit0 write has no effect", st, 8'h03);
    bus_wr(2, 8'h01);
    bus_rd(2, st);
    chk(st == 8'h01, "R11 end flag cleared by write of 0", st, 8'h01);

    // R10: enables
    bus_wr(1, 8'h03);
    @(negedge clk);
    chk(irq_txe == 1'b1, "R10 irq_txe with empty and enable", irq_txe, 1);
    chk(irq_end == 1'b0, "R10 irq_end low while end flag clear", irq_end, 0);

    // R2/R3/R8: chained frames
    bus_wr(0, 8'hA5);
    bus_rd(2, st);
    chk(st[1] == 1'b0, "R2 data write clears end flag", st[1], 0);
    wait_empty();
    chk(irq_txe == 1'b1, "R3 empty set again after load", irq_txe, 1);
    bus_wr(0, 8'h3C);
    bus_rd(2, st);
    chk(st[1:0] == 2'b00, "R2 data write while busy clears both flags", st[1:0], 0);
    chk(irq_txe == 1'b0, "R10 irq_txe low while byte waits", irq_txe, 0);
    wait_done();
    chk(gaps[1] < T, "R8 second frame follows without idle bit", gaps[1], T - 1);
    bus_rd(2, st);
    chk(st[1:0] == 2'b11, "R9 end flag set after last frame", st[1:0], 3);
    chk(irq_end == 1'b1, "R10 irq_end with end flag and enable", irq_end, 1);
    low_seen = 0;
    for (int i = 0; i < 3 * T * 2; i++) begin
      @(negedge clk);
      if (!txd) low_seen++;
    end
    chk(low_seen == 0, "R9 line stays at mark after end", low_seen, 0);

    // Directed formats
    send_one(7'h07, 8'hB4);  // R5 even parity
    send_one(7'h0F, 8'h01);  // R5 odd parity
    send_one(7'h13, 8'h3C);  // R7 two stop bits
    send_one(7'h63, 8'h55);  // R6 mp bit 1
    send_one(7'h27, 8'hAA);  // R6 mp bit 0 overrides parity
    send_one(7'h1F, 8'h00);  // R5 R7 odd parity, two stops

    // Random bursts
    for (int it = 0; it < 30; it++) begin
      int nby;
      logic [6:0] c;
      wait_done();
      c = {$urandom % 2 == 0, $urandom % 3 == 0, $urandom % 2 == 0,
           $urandom % 2 == 0, $urandom % 2 == 0, 2'b11};
      c[6:2] = 5'($urandom);
      bus_wr(1, {1'b0, c});
      nby = 1 + ($urandom % 4);
      for (int b = 0; b < nby; b++) begin
        if (b > 0) begin
          wait_empty();
          repeat ($urandom % 300) @(negedge clk);
        end
        bus_wr(0, 8'($urandom));
      end
    end
    wait_done();
    chk(fr_done == q_wr, "R3 every byte sent once", fr_done, q_wr);

    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule